// File: doc/BRIEF.md
# Programmable Asynchronous Memory Strobe Sequencer

This block produces the control strobes for one access to an external parallel memory or peripheral. A host raises a request with a direction, a beat count and a set of tick counts for the selected chip-select. The block accepts the request only when idle and captures the tick counts at that moment. It then runs a tick counter from zero. Chip-select, address-valid, output-enable and write-enable are active-low. Each one goes low at its own programmed tick and returns high at its own programmed tick.

Reads and writes use separate release ticks for chip-select and address-valid, and separate total cycle lengths. The block marks read-data sampling points with pulses. For a page access, these pulses repeat at the programmed beat spacing. On writes it marks the write-capture point and the window in which write data drives the muxed bus. One clock after the counter reaches the cycle length, it pulses done and returns to idle.

A separate divider gives a clock-enable pulse every 1 to 4 functional clocks. It runs only while read or write synchronous mode is selected.

Top module: `strobe_seq`

## Requirements
- R1: After reset and while idle, all four strobes are high (inactive), and `done`, `busy`, `rdSample`, `wrStrobe` and `dataDrive` are low.
- R2: A request raised while idle is taken at a rising edge. The next cycle is access tick k=0, and k rises by one per clock. The access covers ticks 0..L, where L is `rdCycle` for reads (`reqWrite`=0) and `wrCycle` for writes (`reqWrite`=1). `done` is high for exactly one cycle, at k=L+1. `busy` is high from k=0 through k=L+1 and low afterwards.
- R3: During the access, `csN` is low exactly at ticks k with `csOn` <= k < release. The release tick is `csRdOff` for reads and `csWrOff` for writes. `advN` follows the same rule with `advOn`, `advRdOff` and `advWrOff`.
- R4: On reads, `oeN` is low exactly at ticks `oeOn` <= k < `oeOff`, and `weN` stays high. On writes, `weN` is low exactly at ticks `weOn` <= k < `weOff`, and `oeN` stays high.
- R5: A request presented while `busy` is high, including the `done` cycle, is ignored. The running access and its timing are unaffected, and the block is idle in the cycle after `done`.
- R6: On reads with `reqBeats`=B, `rdSample` pulses at ticks `accessTick` + i*`pageTick` for i = 0..B-1, provided the tick is <= L. A `pageTick` of 0 yields only the first pulse. B=0 yields none. No pulses occur on writes.
- R7: On writes, `wrStrobe` pulses once at tick `wrAccessTick`, provided that tick is <= L. It never pulses on reads.
- R8: On writes, `dataDrive` is high exactly at ticks `wrMuxTick` <= k <= L. It is low on reads and outside accesses.
- R9: While `syncRd` or `syncWr` is high, `syncTick` pulses once every `divCode`+1 clocks. The divide code is the ratio minus one. Counting the first cycle after the enabling edge as j=0, the pulse falls at j where (j+1) mod (`divCode`+1) = 0. With both mode bits low, `syncTick` stays low.
- R10: Every timing field, `reqWrite` and `reqBeats` are sampled only when the request is accepted. Changing them during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rstN | input | 1 | active-low synchronous reset |
| reqValid | input | 1 | access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBeats | input | 3 | number of read sample beats |
| csOn | input | 4 | chip-select assert tick |
| csRdOff | input | 5 | chip-select release tick, reads |
| csWrOff | input | 5 | chip-select release tick, writes |
| advOn | input | 4 | address-valid assert tick |
| advRdOff | input | 5 | address-valid release tick, reads |
| advWrOff | input | 5 | address-valid release tick, writes |
| oeOn | input | 4 | output-enable assert tick |
| oeOff | input | 5 | output-enable release tick |
| weOn | input | 4 | write-enable assert tick |
| weOff | input | 5 | write-enable release tick |
| rdCycle | input | 5 | read cycle length in ticks |
| wrCycle | input | 5 | write cycle length in ticks |
| accessTick | input | 5 | first read sample tick |
| pageTick | input | 4 | tick spacing between page beats |
| wrAccessTick | input | 5 | write capture tick |
| wrMuxTick | input | 4 | tick at which write data drives the muxed bus |
| syncRd | input | 1 | read synchronous mode |
| syncWr | input | 1 | write synchronous mode |
| divCode | input | 2 | clock divide ratio minus one |
| csN | output | 1 | chip-select, active low |
| advN | output | 1 | address-valid, active low |
| oeN | output | 1 | output-enable, active low |
| weN | output | 1 | write-enable, active low |
| rdSample | output | 1 | read-data sample pulse |
| wrStrobe | output | 1 | write capture pulse |
| dataDrive | output | 1 | write data on muxed bus |
| done | output | 1 | one-cycle end-of-access pulse |
| busy | output | 1 | access in progress |
| syncTick | output | 1 | divided clock enable |

## Verification
The assertions assume that `divCode` and the synchronous-mode bits stay steady while the divider period is being checked. They also assume that the latched counts are whatever was present at acceptance, with no ordering required between on and off ticks. The stimulus therefore drives the divider inputs only from an idle, disabled state and holds them through each check window. The access sweep deliberately covers release ticks below assert ticks, lengths shorter than the strobe windows, zero page spacing and zero beats. After tick 0 of every access it inverts all captured inputs, so every cycle's expectation depends solely on the values taken at acceptance.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } seqStateT;

  typedef struct packed {
    logic load;
    logic run;
  } seqCtlT;
endpackage

// File: rtl/strobe_seq_ctl.sv
module strobe_seq_ctl
  import strobe_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   atEnd,
  output seqCtlT ctl,
  output logic   done,
  output logic   busy
);
  seqStateT state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    done     = 1'b0;
    stateNxt = state;
    case (state)
      S_IDLE: if (reqValid) begin
        ctl.load = 1'b1;
        stateNxt = S_RUN;
      end
      S_RUN: begin
        ctl.run = 1'b1;
        if (atEnd) stateNxt = S_FIN;
      end
      S_FIN: begin
        done     = 1'b1;
        stateNxt = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

  // R2: done lasts one cycle and the block is idle afterwards
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  // R2: an accepted request always starts a running access
  a_r2_load_then_run: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> ctl.run);
  // R5: an access in progress is never abandoned before done
  a_r5_no_abort: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
endmodule

// File: rtl/strobe_seq_div.sv
module strobe_seq_div #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             en,
  input  logic [DIV_W-1:0] divCode,
  output logic             syncTick
);
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                  divCnt <= '0;
    else if (!en)               divCnt <= '0;
    else if (divCnt == divCode) divCnt <= '0;
    else                        divCnt <= divCnt + 1'b1;
  end

  assign syncTick = en && (divCnt == '0);

  // R9: with a ratio above one, pulses are never back to back
  a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    (en && $past(en) && (divCode != '0) && $stable(divCode) && syncTick)
      |=> !syncTick);
endmodule

// File: rtl/strobe_seq_dp.sv
module strobe_seq_dp
  import strobe_seq_pkg::*;
#(
  parameter int ON_W   = 4,
  parameter int OFF_W  = 5,
  parameter int PAGE_W = 4,
  parameter int BEAT_W = 3,
  parameter bit WR_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtlT            ctl,
  input  logic              reqWrite,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [ON_W-1:0]   csOn,
  input  logic [OFF_W-1:0]  csRdOff,
  input  logic [OFF_W-1:0]  csWrOff,
  input  logic [ON_W-1:0]   advOn,
  input  logic [OFF_W-1:0]  advRdOff,
  input  logic [OFF_W-1:0]  advWrOff,
  input  logic [ON_W-1:0]   oeOn,
  input  logic [OFF_W-1:0]  oeOff,
  input  logic [ON_W-1:0]   weOn,
  input  logic [OFF_W-1:0]  weOff,
  input  logic [OFF_W-1:0]  rdCycle,
  input  logic [OFF_W-1:0]  wrCycle,
  input  logic [OFF_W-1:0]  accessTick,
  input  logic [PAGE_W-1:0] pageTick,
  input  logic [OFF_W-1:0]  wrAccessTick,
  input  logic [ON_W-1:0]   wrMuxTick,
  output logic              atEnd,
  output logic              csN,
  output logic              advN,
  output logic              oeN,
  output logic              weN,
  output logic              rdSample,
  output logic              wrStrobe,
  output logic              dataDrive
);
  localparam int NXT_W = OFF_W + PAGE_W + BEAT_W;

  // only the direction-selected release ticks and length are kept
  typedef struct packed {
    logic              isWr;
    logic [ON_W-1:0]   csOn;
    logic [OFF_W-1:0]  csOff;
    logic [ON_W-1:0]   advOn;
    logic [OFF_W-1:0]  advOff;
    logic [ON_W-1:0]   oeOn;
    logic [OFF_W-1:0]  oeOff;
    logic [ON_W-1:0]   weOn;
    logic [OFF_W-1:0]  weOff;
    logic [OFF_W-1:0]  len;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  wrPoint;
    logic [ON_W-1:0]   muxOn;
  } tmgT;

  tmgT               lat;
  tmgT               capIn;
  logic [OFF_W-1:0]  cnt;
  logic [NXT_W-1:0]  nextSample;
  logic [BEAT_W-1:0] beatsLeft;
  logic [OFF_W-1:0]  wrPointIn;
  logic [ON_W-1:0]   muxOnIn;
  logic              active;
  logic              rdHit;

  generate
    if (WR_EXT) begin : g_wr_ext
      assign wrPointIn = wrAccessTick;
      assign muxOnIn   = wrMuxTick;
    end else begin : g_wr_base
      assign wrPointIn = accessTick;
      assign muxOnIn   = '0;
    end
  endgenerate

  always_comb begin
    capIn.isWr    = reqWrite;
    capIn.csOn    = csOn;
    capIn.csOff   = reqWrite ? csWrOff : csRdOff;
    capIn.advOn   = advOn;
    capIn.advOff  = reqWrite ? advWrOff : advRdOff;
    capIn.oeOn    = oeOn;
    capIn.oeOff   = oeOff;
    capIn.weOn    = weOn;
    capIn.weOff   = weOff;
    capIn.len     = reqWrite ? wrCycle : rdCycle;
    capIn.page    = pageTick;
    capIn.wrPoint = wrPointIn;
    capIn.muxOn   = muxOnIn;
  end

  function automatic logic inWin(input logic [OFF_W-1:0] c,
                                 input logic [ON_W-1:0]  on,
                                 input logic [OFF_W-1:0] off);
    return (c >= OFF_W'(on)) && (c < off);
  endfunction

  assign active = ctl.run;
  assign rdHit  = active && !lat.isWr && (NXT_W'(cnt) == nextSample)
                  && (beatsLeft != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lat        <= '0;
      cnt        <= '0;
      nextSample <= '0;
      beatsLeft  <= '0;
    end else if (ctl.load) begin
      lat        <= capIn;
      cnt        <= '0;
      nextSample <= NXT_W'(accessTick);
      beatsLeft  <= reqWrite ? '0 : reqBeats;
    end else if (ctl.run) begin
      cnt <= cnt + 1'b1;
      if (rdHit) begin
        nextSample <= nextSample + NXT_W'(lat.page);
        beatsLeft  <= beatsLeft - 1'b1;
      end
    end else begin
      cnt <= '0;
    end
  end

  assign atEnd     = (cnt == lat.len);
  assign csN       = ~(active && inWin(cnt, lat.csOn, lat.csOff));
  assign advN      = ~(active && inWin(cnt, lat.advOn, lat.advOff));
  assign oeN       = ~(active && !lat.isWr && inWin(cnt, lat.oeOn, lat.oeOff));
  assign weN       = ~(active && lat.isWr && inWin(cnt, lat.weOn, lat.weOff));
  assign rdSample  = rdHit;
  assign wrStrobe  = active && lat.isWr && (cnt == lat.wrPoint);
  assign dataDrive = active && lat.isWr && (cnt >= OFF_W'(lat.muxOn));

  // R4: the two data-direction strobes are never low together
  a_r4_oe_we_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));
  // R2: the tick counter never runs past the captured length
  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rstN)
    ctl.run |-> (cnt <= lat.len));
  // R6: zero page spacing gives no repeated sample on the next tick
  a_r6_no_zero_repeat: assert property (@(posedge clk) disable iff (!rstN)
    (rdSample && (lat.page == '0)) |=> !rdSample);
  // R8: once driving, write data stays on the bus until the last tick
  a_r8_drive_holds: assert property (@(posedge clk) disable iff (!rstN)
    (dataDrive && !atEnd) |=> dataDrive);
endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter int ON_W   = 4,
  parameter int OFF_W  = 5,
  parameter int PAGE_W = 4,
  parameter int BEAT_W = 3,
  parameter int DIV_W  = 2,
  parameter bit WR_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BEAT_W-1:0] reqBeats,
  input  logic [ON_W-1:0]   csOn,
  input  logic [OFF_W-1:0]  csRdOff,
  input  logic [OFF_W-1:0]  csWrOff,
  input  logic [ON_W-1:0]   advOn,
  input  logic [OFF_W-1:0]  advRdOff,
  input  logic [OFF_W-1:0]  advWrOff,
  input  logic [ON_W-1:0]   oeOn,
  input  logic [OFF_W-1:0]  oeOff,
  input  logic [ON_W-1:0]   weOn,
  input  logic [OFF_W-1:0]  weOff,
  input  logic [OFF_W-1:0]  rdCycle,
  input  logic [OFF_W-1:0]  wrCycle,
  input  logic [OFF_W-1:0]  accessTick,
  input  logic [PAGE_W-1:0] pageTick,
  input  logic [OFF_W-1:0]  wrAccessTick,
  input  logic [ON_W-1:0]   wrMuxTick,
  input  logic              syncRd,
  input  logic              syncWr,
  input  logic [DIV_W-1:0]  divCode,
  output logic              csN,
  output logic              advN,
  output logic              oeN,
  output logic              weN,
  output logic              rdSample,
  output logic              wrStrobe,
  output logic              dataDrive,
  output logic              done,
  output logic              busy,
  output logic              syncTick
);
  seqCtlT ctl;
  logic   atEnd;

  strobe_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .atEnd(atEnd),
    .ctl(ctl), .done(done), .busy(busy)
  );

  strobe_seq_dp #(
    .ON_W(ON_W), .OFF_W(OFF_W), .PAGE_W(PAGE_W), .BEAT_W(BEAT_W), .WR_EXT(WR_EXT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqBeats(reqBeats),
    .csOn(csOn), .csRdOff(csRdOff), .csWrOff(csWrOff),
    .advOn(advOn), .advRdOff(advRdOff), .advWrOff(advWrOff),
    .oeOn(oeOn), .oeOff(oeOff), .weOn(weOn), .weOff(weOff),
    .rdCycle(rdCycle), .wrCycle(wrCycle), .accessTick(accessTick),
    .pageTick(pageTick), .wrAccessTick(wrAccessTick), .wrMuxTick(wrMuxTick),
    .atEnd(atEnd), .csN(csN), .advN(advN), .oeN(oeN), .weN(weN),
    .rdSample(rdSample), .wrStrobe(wrStrobe), .dataDrive(dataDrive)
  );

  strobe_seq_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rstN(rstN), .en(syncRd | syncWr), .divCode(divCode),
    .syncTick(syncTick)
  );
endmodule

// File: tb/strobe_seq_tb.sv
module strobe_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rstN, reqValid, reqWrite;
  logic [2:0] reqBeats;
  logic [3:0] csOn, advOn, oeOn, weOn, pageTick, wrMuxTick;
  logic [4:0] csRdOff, csWrOff, advRdOff, advWrOff, oeOff, weOff;
  logic [4:0] rdCycle, wrCycle, accessTick, wrAccessTick;
  logic       syncRd, syncWr;
  logic [1:0] divCode;
  logic csN, advN, oeN, weN, rdSample, wrStrobe, dataDrive, done, busy, syncTick;

  strobe_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBeats(reqBeats), .csOn(csOn), .csRdOff(csRdOff), .csWrOff(csWrOff),
    .advOn(advOn), .advRdOff(advRdOff), .advWrOff(advWrOff),
    .oeOn(oeOn), .oeOff(oeOff), .weOn(weOn), .weOff(weOff),
    .rdCycle(rdCycle), .wrCycle(wrCycle), .accessTick(accessTick),
    .pageTick(pageTick), .wrAccessTick(wrAccessTick), .wrMuxTick(wrMuxTick),
    .syncRd(syncRd), .syncWr(syncWr), .divCode(divCode),
    .csN(csN), .advN(advN), .oeN(oeN), .weN(weN), .rdSample(rdSample),
    .wrStrobe(wrStrobe), .dataDrive(dataDrive), .done(done), .busy(busy),
    .syncTick(syncTick)
  );

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit expSample(int k, int acc, int pg, int beats);
    for (int i = 0; i < beats; i++) begin
      if (pg == 0 && i > 0) break;
      if (k == acc + i * pg) return 1'b1;
    end
    return 1'b0;
  endfunction

  // one access; called right after a negedge; expectations from R2..R8, R10
  task automatic runAccess(input bit w, input int len, input int on,
                           input int off, input int li, input int oi,
                           input int fi, input bit hold);
    int eCsOn, eCsOff, eAdvOn, eAdvOff, eOeOn, eOeOff, eWeOn, eWeOff;
    int eAcc, ePage, eBeats, eWrAcc, eMux;
    bit eCs, eAdv, eOe, eWe, eRd, eWr, eDrv;
    eCsOn  = on;              eAdvOn  = (on + 3) % 16;
    eOeOn  = (on + 1) % 16;   eWeOn   = on;
    eOeOff = (off + 2) % 32;  eWeOff  = (off + 9) % 32;
    eAcc   = (on * 2 + li) % 32;
    ePage  = (fi * 3 + oi) % 16;
    eBeats = (li + oi) % 8;
    eWrAcc = (off + on) % 32;
    eMux   = (on + fi) % 16;
    csOn = 4'(eCsOn); advOn = 4'(eAdvOn); oeOn = 4'(eOeOn); weOn = 4'(eWeOn);
    csRdOff  = 5'(off);            csWrOff  = 5'((off + 7) % 32);
    advRdOff = 5'((off + 5) % 32); advWrOff = 5'(off);
    oeOff = 5'(eOeOff); weOff = 5'(eWeOff);
    rdCycle = w ? 5'((len + 11) % 32) : 5'(len);
    wrCycle = w ? 5'(len) : 5'((len + 11) % 32);
    accessTick = 5'(eAcc); pageTick = 4'(ePage); reqBeats = 3'(eBeats);
    wrAccessTick = 5'(eWrAcc); wrMuxTick = 4'(eMux);
    eCsOff  = w ? (off + 7) % 32 : off;
    eAdvOff = w ? off : (off + 5) % 32;
    reqWrite = w;
    reqValid = 1'b1;
    for (int k = 0; k <= len + 2; k++) begin
      @(negedge clk);
      if (k <= len) begin
        eCs  = (k >= eCsOn) && (k < eCsOff);
        eAdv = (k >= eAdvOn) && (k < eAdvOff);
        eOe  = !w && (k >= eOeOn) && (k < eOeOff);
        eWe  = w && (k >= eWeOn) && (k < eWeOff);
        eRd  = !w && expSample(k, eAcc, ePage, eBeats);
        eWr  = w && (k == eWrAcc);
        eDrv = w && (k >= eMux);
        chk("R3 R10 cs/adv", {6'b0, csN, advN}, {6'b0, !eCs, !eAdv});
        chk("R4 R10 oe/we", {6'b0, oeN, weN}, {6'b0, !eOe, !eWe});
        chk("R6 R10 rdSample", {7'b0, rdSample}, {7'b0, eRd});
        chk("R7 R10 wrStrobe", {7'b0, wrStrobe}, {7'b0, eWr});
        chk("R8 R10 dataDrive", {7'b0, dataDrive}, {7'b0, eDrv});
        chk("R2 R5 done/busy", {6'b0, done, busy}, 8'h01);
      end else if (k == len + 1) begin
        chk("R2 end strobes", {4'b0, csN, advN, oeN, weN}, 8'h0f);
        chk("R2 done/busy", {6'b0, done, busy}, 8'h03);
        chk("R2 end pulses", {5'b0, rdSample, wrStrobe, dataDrive}, 8'h00);
      end else begin
        chk("R2 R5 back to idle", {6'b0, done, busy}, 8'h00);
        chk("R5 idle strobes", {4'b0, csN, advN, oeN, weN}, 8'h0f);
      end
      if (k == 0) begin
        // R10: scramble every captured input mid-access
        reqWrite = ~reqWrite; reqBeats = ~reqBeats;
        csOn = ~csOn; csRdOff = ~csRdOff; csWrOff = ~csWrOff;
        advOn = ~advOn; advRdOff = ~advRdOff; advWrOff = ~advWrOff;
        oeOn = ~oeOn; oeOff = ~oeOff; weOn = ~weOn; weOff = ~weOff;
        rdCycle = ~rdCycle; wrCycle = ~wrCycle; accessTick = ~accessTick;
        pageTick = ~pageTick; wrAccessTick = ~wrAccessTick; wrMuxTick = ~wrMuxTick;
        if (!hold) reqValid = 1'b0;
      end
      if (k == len + 1) reqValid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nBad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{0, 3, 9, 20, 31};
    int ons[4]  = '{0, 2, 5, 15};
    int offs[5] = '{0, 1, 4, 10, 31};
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqBeats = '0;
    csOn = '0; csRdOff = '0; csWrOff = '0; advOn = '0; advRdOff = '0;
    advWrOff = '0; oeOn = '0; oeOff = '0; weOn = '0; weOff = '0;
    rdCycle = '0; wrCycle = '0; accessTick = '0; pageTick = '0;
    wrAccessTick = '0; wrMuxTick = '0; syncRd = 1'b0; syncWr = 1'b0; divCode = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset/idle state
    chk("R1 strobes", {4'b0, csN, advN, oeN, weN}, 8'h0f);
    chk("R1 flags", {3'b0, rdSample, wrStrobe, dataDrive, done, busy}, 8'h00);
    chk("R1 syncTick", {7'b0, syncTick}, 8'h00);

    for (int w = 0; w < 2; w++)
      for (int li = 0; li < 5; li++)
        for (int oi = 0; oi < 4; oi++)
          for (int fi = 0; fi < 5; fi++)
            runAccess(w[0], lens[li], ons[oi], offs[fi], li, oi, fi, ((oi + fi) % 2) == 1);

    @(negedge clk);
    chk("R1 idle after sweep", {4'b0, csN, advN, oeN, weN}, 8'h0f);

    // R9 divider sweep: mode 0 read-sync, 1 write-sync, 2 neither
    for (int m = 0; m < 3; m++)
      for (int c = 0; c < 4; c++) begin
        syncRd = 1'b0; syncWr = 1'b0;
        repeat (2) @(negedge clk);
        divCode = 2'(c);
        syncRd = (m == 0);
        syncWr = (m == 1);
        for (int j = 0; j < 12; j++) begin
          @(negedge clk);
          chk("R9 syncTick", {7'b0, syncTick},
              {7'b0, (m != 2) && (((j + 1) % (c + 1)) == 0)});
        end
      end
    syncRd = 1'b0; syncWr = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule